// File: doc/BRIEF.md
# Stack Call/Return Execution Unit

This unit carries out the four stack instructions of a 16-bit processor: subroutine call, subroutine return, push and pop. The instructions occupy opcode space that the base instruction set leaves unused. Register 15 serves as the stack pointer. The stack grows toward lower addresses and moves only 16-bit words.

The sequencer raises `start` with the fetched opcode and the address of the word that follows it. The unit then works through a single register-file port and a word-wide memory port with a ready handshake. It resolves the operand address, performs the stack transfer and writes back the stack pointer. It ends with a one-cycle `done` pulse, and a new program counter when the instruction changes it. An opcode the unit does not recognise completes at once and leaves nothing changed.

Top module: `stk_exec_unit`

## Requirements
- R1: Decoding works as follows. When the opcode ANDed with 0xFFC0 gives 0x0C80, the instruction is a call. When it gives 0x0D00, it is a push. When it gives 0x0F00, it is a pop. The exact word 0x0C00 is a return. Bits [5:4] hold the operand mode and bits [3:0] hold the operand register.
- R2: Push first resolves its source value and then lowers R15 by 2. It then writes the source word to memory at the lowered R15.
- R3: Pop reads the word at R15 and then raises R15 by 2. It then writes the word to the destination operand. When the destination is R15 in mode 00, the popped word is the final value of R15.
- R4: Call writes the return address to memory at R15-2 and leaves R15 lowered by 2. The return address is `pc_in`, plus 2 when an address word follows the opcode. The new program counter is the operand's effective address, or the register value itself in mode 00.
- R5: Return reads the word at R15, raises R15 by 2 and reports that word as the new program counter.
- R6: The operand modes are 00 register, 01 register indirect, 10 address word and 11 indirect with post-increment. In mode 10 the address word is read from memory at `pc_in` and the register contents are added to it, unless the register field is 0. In mode 10, push and pop report `pc_in`+2 as the new program counter.
- R7: In mode 11 the operand register is raised by 2 before the stack is accessed. This also holds when the operand register is R15.
- R8: Every stack memory access clears bit 0 of the address. R15 itself keeps its value unmasked.
- R9: An unrecognised opcode raises `done` in the cycle after `start`. It writes no register, makes no memory request and does not update the program counter.
- R10: `mem_req`, `mem_addr` and `mem_we` stay unchanged from the moment a request is raised until `mem_ready` is seen, whatever the memory latency.
- R11: `done` is high for exactly one cycle per instruction. `pc_we` is high only in that same cycle, and no memory request is outstanding then.
- R12: During reset and in the first cycle after it, `done`, `mem_req`, `rf_we` and `pc_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `instr` (honoured when idle) |
| instr | input | 16 | Fetched opcode word |
| pc_in | input | 16 | Address of the word after the opcode |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 4 | Register-file read address |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory access complete |
| pc_we | output | 1 | Program counter update strobe |
| pc_wdata | output | 16 | New program counter |

## Verification
The stack-pointer register write and the stack memory access start in the same cycle. In a pop to a register, the final register write also lands in the cycle that `done` is high. Push R15, pop R15 and post-increment through R15 stress this overlap, because the operand register and the pointer are the same. A mismatch in update order then changes which value survives in R15 or which word reaches memory. Each case is judged by comparing the full register file, the memory and the reported program counter against a reference model derived from the requirements. The tests run with both zero and multi-cycle memory latency.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int IW = 16;

  localparam logic [IW-1:0] GRP_MASK = 16'hFFC0;
  localparam logic [IW-1:0] PAT_CALL = 16'h0C80;
  localparam logic [IW-1:0] PAT_PUSH = 16'h0D00;
  localparam logic [IW-1:0] PAT_POP  = 16'h0F00;
  localparam logic [IW-1:0] PAT_RET  = 16'h0C00;

  typedef enum logic [2:0] {OP_NONE, OP_CALL, OP_RET, OP_PUSH, OP_POP} op_e;

  typedef enum logic [1:0] {
    AM_REG = 2'b00,
    AM_IND = 2'b01,
    AM_SYM = 2'b10,
    AM_INC = 2'b11
  } amode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RDREG, S_EXT, S_AINC, S_OPRD, S_RDSP, S_STORE, S_LOAD, S_POPWR
  } st_e;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic [IW-1:0] instr,
  output op_e           op,
  output amode_e        mode,
  output logic [3:0]    rsel
);
  always_comb begin
    mode = amode_e'(instr[5:4]);
    rsel = instr[3:0];
    if (instr == PAT_RET)                      op = OP_RET;
    else if ((instr & GRP_MASK) == PAT_CALL)   op = OP_CALL;
    else if ((instr & GRP_MASK) == PAT_PUSH)   op = OP_PUSH;
    else if ((instr & GRP_MASK) == PAT_POP)    op = OP_POP;
    else                                       op = OP_NONE;
  end
endmodule

// File: rtl/stk_addr.sv
module stk_addr #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] ext,
  input  logic          use_idx,
  output logic [DW-1:0] sp_up,
  output logic [DW-1:0] sp_dn,
  output logic [DW-1:0] sp_addr,
  output logic [DW-1:0] sp_dn_addr,
  output logic [DW-1:0] idx_ea,
  output logic [DW-1:0] base_inc
);
  localparam logic [DW-1:0] WSTEP = DW'(2);

  always_comb begin
    sp_up      = sp + WSTEP;
    sp_dn      = sp - WSTEP;
    sp_addr    = {sp[DW-1:1], 1'b0};
    sp_dn_addr = {sp_dn[DW-1:1], 1'b0};
    idx_ea     = ext + (use_idx ? base : '0);
    base_inc   = base + WSTEP;
  end
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NREG   = 16,
  parameter int SP_REG = 15,
  localparam int RW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] pc_in,
  output logic          done,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          pc_we,
  output logic [DW-1:0] pc_wdata
);
  localparam logic [RW-1:0] SP_IDX = RW'(SP_REG);
  localparam logic [DW-1:0] WSTEP  = DW'(2);

  st_e           st_q;
  op_e           op_q;
  amode_e        mode_q;
  logic [RW-1:0] rsel_q;
  logic [DW-1:0] pc_q, rval_q, ea_q, val_q, tgt_q;

  op_e           dec_op;
  amode_e        dec_mode;
  logic [3:0]    dec_rsel;

  logic [DW-1:0] rval_now, ea_now, tgt_now;
  logic [DW-1:0] sp_up, sp_dn, sp_addr, sp_dn_addr, idx_ea, base_inc;
  st_e           disp_st;
  logic          disp_req;
  logic          idle_w;

  stk_decode u_dec (
    .instr (instr),
    .op    (dec_op),
    .mode  (dec_mode),
    .rsel  (dec_rsel)
  );

  stk_addr #(.DW(DW)) u_addr (
    .sp         (rf_rdata),
    .base       (rval_now),
    .ext        (mem_rdata),
    .use_idx    (rsel_q != '0),
    .sp_up      (sp_up),
    .sp_dn      (sp_dn),
    .sp_addr    (sp_addr),
    .sp_dn_addr (sp_dn_addr),
    .idx_ea     (idx_ea),
    .base_inc   (base_inc)
  );

  assign idle_w = (st_q == S_IDLE);

  // operand value and address as they stand in the current cycle
  always_comb begin
    rval_now = (st_q == S_RDREG) ? rf_rdata : rval_q;
    case (st_q)
      S_RDREG: ea_now = rf_rdata;
      S_EXT:   ea_now = idx_ea;
      default: ea_now = ea_q;
    endcase
    tgt_now = (mode_q == AM_REG) ? rval_now : ea_now;
  end

  // after the operand is resolved: fetch a push source, or go read SP
  always_comb begin
    disp_st  = S_RDSP;
    disp_req = 1'b0;
    if (op_q == OP_PUSH && mode_q != AM_REG) begin
      disp_st  = S_OPRD;
      disp_req = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      op_q      <= OP_NONE;
      mode_q    <= AM_REG;
      rsel_q    <= '0;
      pc_q      <= '0;
      rval_q    <= '0;
      ea_q      <= '0;
      val_q     <= '0;
      tgt_q     <= '0;
      done      <= 1'b0;
      rf_raddr  <= '0;
      rf_we     <= 1'b0;
      rf_waddr  <= '0;
      rf_wdata  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pc_we     <= 1'b0;
      pc_wdata  <= '0;
    end else begin
      rf_we <= 1'b0;
      pc_we <= 1'b0;
      done  <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            op_q   <= dec_op;
            mode_q <= dec_mode;
            rsel_q <= RW'(dec_rsel);
            pc_q   <= pc_in;
            case (dec_op)
              OP_NONE: done <= 1'b1;
              OP_RET: begin
                rf_raddr <= SP_IDX;
                st_q     <= S_RDSP;
              end
              default: begin
                rf_raddr <= RW'(dec_rsel);
                st_q     <= S_RDREG;
              end
            endcase
          end
        end
        S_RDREG: begin
          rval_q <= rf_rdata;
          case (mode_q)
            AM_SYM: begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= pc_q;
              st_q     <= S_EXT;
            end
            AM_INC: begin
              rf_we    <= 1'b1;
              rf_waddr <= rsel_q;
              rf_wdata <= base_inc;
              ea_q     <= rf_rdata;
              st_q     <= S_AINC;
            end
            default: begin
              st_q     <= disp_st;
              tgt_q    <= tgt_now;
              val_q    <= rval_now;
              ea_q     <= ea_now;
              rf_raddr <= SP_IDX;
              if (disp_req) begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= ea_now;
              end
            end
          endcase
        end
        S_EXT: begin
          if (mem_ready) begin
            mem_req  <= 1'b0;
            pc_q     <= pc_q + WSTEP;
            st_q     <= disp_st;
            tgt_q    <= tgt_now;
            val_q    <= rval_now;
            ea_q     <= ea_now;
            rf_raddr <= SP_IDX;
            if (disp_req) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= ea_now;
            end
          end
        end
        S_AINC: begin
          st_q     <= disp_st;
          tgt_q    <= tgt_now;
          val_q    <= rval_now;
          rf_raddr <= SP_IDX;
          if (disp_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ea_now;
          end
        end
        S_OPRD: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            val_q   <= mem_rdata;
            st_q    <= S_RDSP;
          end
        end
        S_RDSP: begin
          rf_we    <= 1'b1;
          rf_waddr <= SP_IDX;
          mem_req  <= 1'b1;
          if (op_q == OP_CALL || op_q == OP_PUSH) begin
            mem_we    <= 1'b1;
            mem_addr  <= sp_dn_addr;
            mem_wdata <= (op_q == OP_CALL) ? pc_q : val_q;
            rf_wdata  <= sp_dn;
            st_q      <= S_STORE;
          end else begin
            mem_we   <= 1'b0;
            mem_addr <= sp_addr;
            rf_wdata <= sp_up;
            st_q     <= S_LOAD;
          end
        end
        S_STORE: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            st_q    <= S_IDLE;
            if (op_q == OP_CALL) begin
              pc_we    <= 1'b1;
              pc_wdata <= tgt_q;
            end else if (mode_q == AM_SYM) begin
              pc_we    <= 1'b1;
              pc_wdata <= pc_q;
            end
          end
        end
        S_LOAD: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            if (op_q == OP_RET) begin
              pc_we    <= 1'b1;
              pc_wdata <= mem_rdata;
              done     <= 1'b1;
              st_q     <= S_IDLE;
            end else if (mode_q == AM_REG) begin
              rf_we    <= 1'b1;
              rf_waddr <= rsel_q;
              rf_wdata <= mem_rdata;
              done     <= 1'b1;
              st_q     <= S_IDLE;
            end else begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= ea_q;
              mem_wdata <= mem_rdata;
              st_q      <= S_POPWR;
            end
          end
        end
        S_POPWR: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            st_q    <= S_IDLE;
            if (mode_q == AM_SYM) begin
              pc_we    <= 1'b1;
              pc_wdata <= pc_q;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk
  import stk_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int SP_REG = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          idle,
  input logic [IW-1:0] instr,
  input logic          done,
  input logic          rf_we,
  input logic [RW-1:0] rf_waddr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          pc_we
);
  logic known;
  assign known = (instr == PAT_RET) || ((instr & GRP_MASK) == PAT_CALL) ||
                 ((instr & GRP_MASK) == PAT_PUSH) || ((instr & GRP_MASK) == PAT_POP);

  // stack access starts together with the SP write-back
  assert_stack_even_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && rf_we && rf_waddr == RW'(SP_REG)) |-> !mem_addr[0]);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_pc_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> done);

  assert_done_no_req_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  assert_unknown_nop_R9: assert property (@(posedge clk) disable iff (rst)
    (start && idle && !known) |=> (done && !rf_we && !mem_req && !pc_we));
endmodule

bind stk_exec_unit stk_exec_chk #(.DW(DW), .RW(RW), .SP_REG(SP_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .idle      (idle_w),
  .instr     (instr),
  .done      (done),
  .rf_we     (rf_we),
  .rf_waddr  (rf_waddr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .pc_we     (pc_we)
);

// File: tb/test_stk_exec_unit.sv
module test_stk_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  localparam logic [15:0] PCI = 16'h0180;

  // {opcode, address word placed at pc_in}
  localparam logic [31:0] VEC [NV] = '{
    32'h0D01_0000,  // push R1               R2
    32'h0D12_0000,  // push *R2              R2
    32'h0D20_0040,  // push @>0040           R6
    32'h0D21_0004,  // push @4(R1)           R6
    32'h0D33_0000,  // push *R3+             R7
    32'h0F04_0000,  // pop R4                R3
    32'h0F12_0000,  // pop *R2               R3
    32'h0F20_0060,  // pop @>0060            R6
    32'h0C85_0000,  // call R5               R4
    32'h0C00_0000,  // ret                   R5
    32'h0CA0_0090,  // call @>0090           R4 R6
    32'h0C00_0000,  // ret                   R5
    32'h0CB6_0000,  // call *R6+             R7
    32'h0C00_0000,  // ret
    32'h0D0F_0000,  // push R15 (old SP)
    32'h0F0F_0000,  // pop R15: popped word wins
    32'h0D3F_0000,  // push *R15+            R7
    32'h0F37_0000,  // pop *R7+              R7
    32'h0E00_0000,  // unrecognised          R9
    32'h0C40_0000   // unrecognised          R9
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [15:0] instr, pc_in;
  logic        done;
  logic [3:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        pc_we;
  logic [15:0] pc_wdata;

  logic [15:0] rf [16];
  logic [15:0] mem [256];
  logic [15:0] er [16];
  logic [15:0] em [256];
  bit          exp_pcw;
  logic [15:0] exp_pc;
  int          lat = 0, wcnt = 0, odd_acc = 0;
  int          tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_exec_unit i_stk_exec_unit (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_in(pc_in), .done(done),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  always @(posedge clk) begin
    mem_ready <= 1'b0;
    if (mem_req && !mem_ready) begin
      if (wcnt >= lat) begin
        wcnt      <= 0;
        mem_ready <= 1'b1;
        if (mem_addr[0]) odd_acc <= odd_acc + 1;
        if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[8:1]];
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model written from the requirements
  task automatic ref_exec(input logic [15:0] ins, input logic [15:0] pci);
    logic [1:0]  md;
    logic [3:0]  r;
    logic [15:0] rv, ea, pcn, v, sp;
    bit isc, isp, ispo, isr;
    isc  = (ins & 16'hFFC0) == 16'h0C80;
    isp  = (ins & 16'hFFC0) == 16'h0D00;
    ispo = (ins & 16'hFFC0) == 16'h0F00;
    isr  = ins == 16'h0C00;
    md = ins[5:4]; r = ins[3:0]; pcn = pci; ea = 16'h0; rv = 16'h0;
    exp_pcw = 1'b0; exp_pc = 16'h0;
    if (isc || isp || ispo) begin
      rv = er[r];
      case (md)
        2'b01: ea = rv;
        2'b10: begin ea = em[pcn[8:1]] + ((r != 0) ? rv : 16'h0); pcn = pcn + 2; end
        2'b11: begin ea = rv; er[r] = rv + 2; end
        default: ea = 16'h0;
      endcase
    end
    if (isc) begin
      sp = er[15] - 2; er[15] = sp; em[sp[8:1]] = pcn;
      exp_pcw = 1'b1; exp_pc = (md == 2'b00) ? rv : ea;
    end else if (isp) begin
      v = (md == 2'b00) ? rv : em[ea[8:1]];
      sp = er[15] - 2; er[15] = sp; em[sp[8:1]] = v;
      exp_pcw = (md == 2'b10); exp_pc = pcn;
    end else if (ispo) begin
      sp = er[15]; v = em[sp[8:1]]; er[15] = sp + 2;
      if (md == 2'b00) er[r] = v; else em[ea[8:1]] = v;
      exp_pcw = (md == 2'b10); exp_pc = pcn;
    end else if (isr) begin
      sp = er[15]; exp_pc = em[sp[8:1]]; er[15] = sp + 2; exp_pcw = 1'b1;
    end
  endtask

  task automatic run_dut(input logic [15:0] ins, input logic [15:0] pci, output int cyc,
                         output bit gpw, output logic [15:0] gpc, output bit early_pc,
                         output bit dn_after, output bit act);
    gpw = 1'b0; gpc = 16'h0; early_pc = 1'b0; act = 1'b0; cyc = 0;
    @(negedge clk); instr = ins; pc_in = pci; start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 500) begin
      if (pc_we) early_pc = 1'b1;
      if (rf_we || mem_req) act = 1'b1;
      @(negedge clk); cyc++;
    end
    if (rf_we || mem_req) act = 1'b1;
    if (pc_we) begin gpw = 1'b1; gpc = pc_wdata; end
    @(negedge clk);
    dn_after = done;
  endtask

  task automatic compare(input string tag, input bit gpw, input logic [15:0] gpc);
    int bad_r, bad_m;
    bad_r = -1; bad_m = -1;
    for (int i = 15; i >= 0; i--) if (rf[i] !== er[i]) bad_r = i;
    for (int i = 255; i >= 0; i--) if (mem[i] !== em[i]) bad_m = i;
    if (bad_r >= 0) chk(1'b0, {tag, " regs"}, {16'(bad_r), rf[bad_r]}, {16'(bad_r), er[bad_r]});
    else chk(1'b1, tag, 0, 0);
    if (bad_m >= 0) chk(1'b0, {tag, " mem"}, {16'(bad_m), mem[bad_m]}, {16'(bad_m), em[bad_m]});
    else chk(1'b1, tag, 0, 0);
    chk(gpw == exp_pcw && (!exp_pcw || gpc == exp_pc), {tag, " pc"}, {15'h0, gpw, gpc}, {15'h0, exp_pcw, exp_pc});
  endtask

  function automatic string tag_of(input logic [15:0] ins);
    string t;
    if (ins == 16'h0C00) t = "R1 R5";
    else if ((ins & 16'hFFC0) == 16'h0C80) t = "R1 R4";
    else if ((ins & 16'hFFC0) == 16'h0D00) t = "R1 R2";
    else if ((ins & 16'hFFC0) == 16'h0F00) t = "R1 R3";
    else t = "R1 R9";
    if (t != "R1 R9" && ins != 16'h0C00) begin
      if (ins[5:4] == 2'b10) t = {t, " R6"};
      if (ins[5:4] == 2'b11) t = {t, " R7"};
    end
    return t;
  endfunction

  task automatic one(input logic [15:0] ins, input logic [15:0] ext, input string tag);
    int cyc; bit gpw, early, dn, act; logic [15:0] gpc;
    mem[PCI[8:1]] = ext; em[PCI[8:1]] = ext;
    ref_exec(ins, PCI);
    run_dut(ins, PCI, cyc, gpw, gpc, early, dn, act);
    compare(tag, gpw, gpc);
    chk(!dn && !early, {tag, " R11 done pulse"}, {dn, early}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc; bit gpw, early, dn, act; logic [15:0] gpc;
    rst = 1'b1; start = 1'b0; instr = 16'h0; pc_in = 16'h0;
    for (int i = 0; i < 15; i++) begin rf[i] = 16'h0020 + 16'(i) * 16'h0010; er[i] = rf[i]; end
    rf[15] = 16'h0100; er[15] = 16'h0100;
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h5A00 ^ (16'(i) * 16'd3); em[i] = mem[i]; end
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !rf_we && !pc_we, "R12 in reset", {done, mem_req, rf_we, pc_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !mem_req && !rf_we && !pc_we, "R12 after reset", {done, mem_req, rf_we, pc_we}, 0);

    for (int v = 0; v < NV; v++) one(VEC[v][31:16], VEC[v][15:0], tag_of(VEC[v][31:16]));

    // R8: odd stack pointer, stack addresses must be even
    rf[15] = 16'h0101; er[15] = 16'h0101; odd_acc = 0;
    one(16'h0D01, 16'h0000, "R8 push odd sp");
    one(16'h0C00, 16'h0000, "R8 ret odd sp");
    chk(odd_acc == 0, "R8 odd stack address", odd_acc, 0);

    // R9: unrecognised opcode, one-cycle completion, no activity
    ref_exec(16'hFFFF, PCI);
    run_dut(16'hFFFF, PCI, cyc, gpw, gpc, early, dn, act);
    chk(cyc == 1, "R9 latency", cyc, 1);
    chk(!act && !gpw, "R9 no effect", {act, gpw}, 0);
    compare("R9 state", gpw, gpc);

    // R10: slow memory
    lat = 3;
    one(16'h0CA1, 16'h0010, "R10 call slow mem");
    one(16'h0F20, 16'h0070, "R10 pop slow mem");
    one(16'h0C00, 16'h0000, "R10 ret slow mem");
    lat = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule